// File: doc/BRIEF.md
# Overlapping-Window Approximate Adder

This block adds two N-bit unsigned operands without a full-length carry chain. The operands are split into a row of 2K-bit windows. Each window starts K bits above the one below it, so neighbouring windows share K bits. Every window is summed on its own with a carry-in of zero. Its lower K bits only serve to predict the carry into its upper K bits, and those upper K bits are the only part of the window that reaches the result. The lowest window is the exception and places all 2K bits of its sum. The top window's carry-out becomes the result's most significant bit. The longest carry path is therefore 2K bits, however wide N is.

The result is wrong only when a carry enters a window from below and that window's lower K bits propagate all the way through, which is uncommon. For this reason the block also exports each window's carry-out and a flag that is set when every bit of the window's lower half propagates, so that a separate detector can find and repair the rare miss.

The logic is purely combinational and has no reset, so the outputs are valid in the same cycle as the operands. Parameter sets where N is not a multiple of K, or where N is less than 2K, are rejected at elaboration.

Top module: `owa_adder`

## Requirements
- R1: `sum_apx[2K-1:0]` equals the low 2K bits of `op_a[2K-1:0] + op_b[2K-1:0]` (window 0, bits placed in full).
- R2: For each window i from 1 to NWIN-1, with NWIN = N/K-1 and window i covering operand bits [iK+2K-1:iK], `sum_apx[iK+2K-1:iK+K]` equals bits [2K-1:K] of that window's zero-carry-in sum.
- R3: `sum_apx[N]` equals the carry-out (bit 2K) of the top window NWIN-1. When N = 2K this makes the block an exact adder.
- R4: `win_carry[i]` equals bit 2K of window i's zero-carry-in 2K-bit sum.
- R5: `win_prop[i]` is 1 exactly when `op_a ^ op_b` is all ones over bits [iK+K-1:iK]. When it is set, the low K bits of that window's sum are all ones.
- R6: If `win_prop[i]` is 0 for every i ≥ 1, then `sum_apx` equals the exact `op_a + op_b`.
- R7: `sum_apx` never exceeds the exact `op_a + op_b`, because a dropped carry can only lower the result.
- R8: The outputs follow the operands within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| sum_apx | output | N+1 | Approximate sum built from the windows |
| win_carry | output | N/K-1 | Carry-out of each window's 2K-bit addition |
| win_prop | output | N/K-1 | Set when the lower half of a window propagates in every bit |

## Verification
The bench sweeps every operand pair of an 8-bit, K=2 build. It also sweeps a 6-bit, K=3 build, which has a single window and must give the exact sum. Both are compared against an arithmetic model of the windowed sum, not against the true sum. If a window's slice were misplaced by K bits, or its carry-in were taken from the window below, many pairs would differ from that model. If the top carry were dropped, the pairs that overflow would come out too small. If a propagate flag looked at the wrong half, it would disagree with its operand pattern. Directed cases on the default 16-bit build ripple a carry across one or two window boundaries, where a correct block must lose that carry.

// File: rtl/owa_pkg.sv
package owa_pkg;

    // Legal shapes: K positive, N a whole number of K-bit steps, at least two steps.
    function automatic bit owa_shape_ok(input int n, input int k);
        if (k < 1) return 1'b0;
        if (n < 2 * k) return 1'b0;
        return (n % k) == 0;
    endfunction

    function automatic int owa_num_windows(input int n, input int k);
        return n / k - 1;
    endfunction

endpackage

// File: rtl/owa_prop.sv
module owa_prop #(
    parameter int K = 4
) (
    input  logic [K-1:0] lo_x,
    input  logic [K-1:0] lo_y,
    output logic         all_prop
);
    logic [K-1:0] half_sum;

    always_comb begin
        half_sum = lo_x ^ lo_y;
        all_prop = &half_sum;
    end
endmodule

// File: rtl/owa_window.sv
module owa_window #(
    parameter int K = 4,
    localparam int WW = 2 * K
) (
    input  logic [WW-1:0] win_x,
    input  logic [WW-1:0] win_y,
    output logic [WW:0]   part,
    output logic          lo_prop
);
    owa_prop #(.K(K)) u_prop (
        .lo_x     (win_x[K-1:0]),
        .lo_y     (win_y[K-1:0]),
        .all_prop (lo_prop)
    );

    always_comb begin
        part = {1'b0, win_x} + {1'b0, win_y};
    end

    always_comb begin
        if (lo_prop) begin
            AST_PROP_LOW_ONES: assert (part[K-1:0] == {K{1'b1}}) else $error("propagating half not all ones"); // R5
        end
    end
endmodule

// File: rtl/owa_assemble.sv
module owa_assemble #(
    parameter int N = 16,
    parameter int K = 4,
    localparam int NWIN = N / K - 1,
    localparam int WW = 2 * K
) (
    input  logic [NWIN-1:0][WW:0] part,
    output logic [N:0]            sum_out
);
    always_comb begin
        sum_out = '0;
        sum_out[WW-1:0] = part[0][WW-1:0];
        for (int i = 1; i < NWIN; i++) begin
            sum_out[i*K+K +: K] = part[i][WW-1:K];
        end
        sum_out[N] = part[NWIN-1][WW];
    end
endmodule

// File: rtl/owa_adder.sv
module owa_adder #(
    parameter int N = 16,
    parameter int K = 4,
    localparam int NWIN = N / K - 1
) (
    input  logic [N-1:0]    op_a,
    input  logic [N-1:0]    op_b,
    output logic [N:0]      sum_apx,
    output logic [NWIN-1:0] win_carry,
    output logic [NWIN-1:0] win_prop
);
    import owa_pkg::*;

    localparam int WW = 2 * K;

    if (!owa_shape_ok(N, K)) begin : g_bad_shape
        $error("owa_adder: N must be a multiple of K and at least 2K");
    end

    logic [NWIN-1:0][WW:0] part;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        owa_window #(.K(K)) u_win (
            .win_x   (op_a[i*K +: WW]),
            .win_y   (op_b[i*K +: WW]),
            .part    (part[i]),
            .lo_prop (win_prop[i])
        );
        assign win_carry[i] = part[i][WW];
    end

    owa_assemble #(.N(N), .K(K)) u_asm (
        .part    (part),
        .sum_out (sum_apx)
    );

    logic [N+1:0] exact_sum;

    always_comb begin
        exact_sum = {2'b00, op_a} + {2'b00, op_b};
        AST_TOP_CARRY: assert (sum_apx[N] == win_carry[NWIN-1]) else $error("top bit mismatch"); // R3
        AST_NO_EXCESS: assert ({1'b0, sum_apx} <= exact_sum) else $error("result above exact"); // R7
    end

    if (NWIN > 1) begin : g_multi
        always_comb begin
            if (win_prop[NWIN-1:1] == '0) begin
                AST_EXACT_NO_PROP: assert ({1'b0, sum_apx} == exact_sum) else $error("miss without propagate"); // R6
            end
        end
    end else begin : g_single
        always_comb begin
            AST_SINGLE_EXACT: assert ({1'b0, sum_apx} == exact_sum) else $error("single window not exact"); // R3
        end
    end
endmodule

// File: tb/owa_adder_bench.sv
`timescale 1ns/1ps
module owa_adder_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] a16, b16;
    logic [16:0] s16;
    logic [2:0]  c16, p16;
    logic [7:0]  a8, b8;
    logic [8:0]  s8;
    logic [2:0]  c8, p8;
    logic [5:0]  a6, b6;
    logic [6:0]  s6;
    logic [0:0]  c6, p6;

    owa_adder u_owa_adder (.op_a(a16), .op_b(b16), .sum_apx(s16), .win_carry(c16), .win_prop(p16));
    owa_adder #(.N(8), .K(2)) u_small8 (.op_a(a8), .op_b(b8), .sum_apx(s8), .win_carry(c8), .win_prop(p8));
    owa_adder #(.N(6), .K(3)) u_small6 (.op_a(a6), .op_b(b6), .sum_apx(s6), .win_carry(c6), .win_prop(p6));

    function automatic logic [63:0] msk(input int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic logic [63:0] wsum(input logic [63:0] x, input logic [63:0] y, input int i, input int k);
        return ((x >> (i*k)) & msk(2*k)) + ((y >> (i*k)) & msk(2*k));
    endfunction

    function automatic logic [63:0] model_sum(input logic [63:0] x, input logic [63:0] y, input int n, input int k);
        int nw = n / k - 1;
        logic [63:0] r = wsum(x, y, 0, k) & msk(2*k);
        for (int i = 1; i < nw; i++) r |= ((wsum(x, y, i, k) >> k) & msk(k)) << (i*k + k);
        r |= ((wsum(x, y, nw-1, k) >> (2*k)) & 64'd1) << n;
        return r;
    endfunction

    function automatic logic [63:0] model_carry(input logic [63:0] x, input logic [63:0] y, input int n, input int k);
        logic [63:0] r = '0;
        for (int i = 0; i < n/k-1; i++) r[i] = wsum(x, y, i, k)[2*k];
        return r;
    endfunction

    function automatic logic [63:0] model_prop(input logic [63:0] x, input logic [63:0] y, input int n, input int k);
        logic [63:0] r = '0;
        for (int i = 0; i < n/k-1; i++) r[i] = (((x ^ y) >> (i*k)) & msk(k)) == msk(k);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input logic [63:0] x, input logic [63:0] y, input int n, input int k,
                             input logic [63:0] s, input logic [63:0] c, input logic [63:0] p);
        logic [63:0] es = model_sum(x, y, n, k);
        logic [63:0] ex = x + y;
        int nw = n / k - 1;
        chk("R1 low window", s & msk(2*k), es & msk(2*k));
        chk("R2 windowed sum", s, es);
        chk("R3 top bit", (s >> n) & 64'd1, (wsum(x, y, nw-1, k) >> (2*k)) & 64'd1);
        chk("R4 window carries", c, model_carry(x, y, n, k));
        chk("R5 propagate flags", p, model_prop(x, y, n, k));
        if ((p >> 1) == 64'd0) chk("R6 exact without propagate", s, ex);
        chk("R7 not above exact", {63'd0, s <= ex}, 64'd1);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a16 = '0; b16 = '0; a8 = '0; b8 = '0; a6 = '0; b6 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 zero operands", {47'd0, s16}, 64'd0);
        chk("R4 zero carries", {61'd0, c16}, 64'd0);

        // R8: operands applied just after an edge are reflected before the next edge
        @(posedge clk); #1 a16 = 16'h00FF; b16 = 16'h0001;
        @(negedge clk);
        chk("R8 same-cycle result", {47'd0, s16}, 64'h0000);
        chk("R5 carry lost at window edge prop", {61'd0, p16}, 64'h2);

        @(posedge clk); #1 a16 = 16'h0FF0; b16 = 16'h0010;
        @(negedge clk);
        chk("R2 two boundaries lose carry", {47'd0, s16}, 64'h0000);
        check_all({48'd0, a16}, {48'd0, b16}, 16, 4, {47'd0, s16}, {61'd0, c16}, {61'd0, p16});

        @(posedge clk); #1 a16 = 16'hFFFF; b16 = 16'hFFFF;
        @(negedge clk);
        chk("R3 overflow top bit", {47'd0, s16}, 64'h1FFFE);

        for (int t = 0; t < 3000; t++) begin
            @(posedge clk); #1 a16 = 16'($urandom); b16 = 16'($urandom);
            @(negedge clk);
            check_all({48'd0, a16}, {48'd0, b16}, 16, 4, {47'd0, s16}, {61'd0, c16}, {61'd0, p16});
        end

        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                @(posedge clk); #1 a8 = 8'(x); b8 = 8'(y); a6 = 6'(x); b6 = 6'(y);
                @(negedge clk);
                check_all(64'(x), 64'(y), 8, 2, {55'd0, s8}, {61'd0, c8}, {61'd0, p8});
                if (x < 64 && y < 64) begin
                    chk("R3 single window exact", {57'd0, s6}, 64'(x + y));
                    check_all(64'(x), 64'(y), 6, 3, {57'd0, s6}, {63'd0, c6}, {63'd0, p6});
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule